// File: doc/BRIEF.md
# Load/Store Address Unit

This block turns a load or store request from a 16-bit load-store processor into one memory access. The memory holds 128 kB organised as 16-bit words. Data pointers are byte addresses into the low 64 kB. Code pointers are word addresses that can reach the whole 128 kB. Memory is little endian: the byte at an even address is the low byte of its word. The unit receives the 8-bit addressing-mode field, the value of the base register that the low nibble of that field names, the stack pointer (register 14), an optional immediate and the access kind. From these it forms a 17-bit byte address, the byte-lane enables and the write data. It also produces a base-register write-back for the auto-modifying modes, and it aligns and zero-extends the data that comes back from a load.

The sequencing is a small state machine with four states. ST_IDLE waits for a request. On a request it moves to ST_ACCESS, or to ST_FAULT when a word access has an odd byte address. ST_ACCESS drives the memory for one cycle, together with any write-back. From there a load moves to ST_RETURN and a store moves back to ST_IDLE. ST_RETURN presents the aligned load result for one cycle and then returns to ST_IDLE. ST_FAULT reports the fault for one cycle and then returns to ST_IDLE. The memory is expected to return read data in the cycle after ST_ACCESS.

Top module: `byte_lsu_agu`

## Requirements
- R1: Modes 0x00 to 0x0e address the byte location {0, base_val} and request no write-back.
- R2: Mode 0x0f (push) addresses {0, sp_val-2} and writes sp_val-2 back to register 14 in the same cycle as the access.
- R3: Modes 0x10 to 0x1e address {0, base_val+imm_val}, wrapping modulo 2^16. Mode 0x1f addresses {0, imm_val}. Neither requests a write-back.
- R4: Modes 0x20 to 0x2e address {0, base_val} and write base_val+imm_val back to the register named by mode bits [3:0].
- R5: Mode 0x2f (pop) addresses {0, sp_val} and writes sp_val+2 back to register 14.
- R6: Modes 0x30 to 0xff address {0, sp_val + (mode-0x30)}, an unsigned offset from 0x00 to 0xcf, with no write-back.
- R7: Word and program-word accesses enable both lanes (mem_be=2'b11) and write st_data unchanged. A byte access enables only mem_be[addr bit 0]. A byte store drives the low byte of st_data on both lanes.
- R8: A word load returns mem_rdata unchanged. A byte load returns the zero-extended byte: mem_rdata[7:0] for an even address and mem_rdata[15:8] for an odd address.
- R9: Program-word kinds address byte {base_val, 0} across the full 17 bits, ignore the mode field and request no write-back.
- R10: A word load or word store with an odd byte address raises fault for exactly one cycle. No memory access, write-back or load result is produced for it. Byte and program-word kinds never fault.
- R11: req_kind codes are 0 word load, 1 word store, 2 byte load, 3 byte store, 4 program-word load and 5 program-word store. A request is taken only in ST_IDLE. ST_ACCESS lasts one cycle, and a load then spends one cycle in ST_RETURN with ld_valid. busy is high outside ST_IDLE, and a request presented while busy is ignored.
- R12: After reset the unit is in ST_IDLE with busy, mem_en, mem_we, wb_en, fault and ld_valid all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Access kind code |
| req_mode | input | 8 | Addressing-mode field |
| base_val | input | 16 | Value of the register named by req_mode[3:0] (ry for program-word kinds) |
| sp_val | input | 16 | Value of register 14 |
| imm_val | input | 16 | Immediate operand |
| st_data | input | 16 | Store source register value |
| busy | output | 1 | High outside ST_IDLE |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 17 | Byte address |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after the access |
| wb_en | output | 1 | Base-register write-back enable |
| wb_reg | output | 4 | Write-back register index |
| wb_val | output | 16 | Write-back value |
| fault | output | 1 | Alignment fault |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 16 | Aligned load result |

## Verification
The hardest case to reach is a fault on an auto-modifying mode. For example, a push with an odd stack pointer must suppress both the memory write and the stack-pointer write-back. The bench brings this about by driving an odd sp_val with mode 0x0f. It then shows that memory was not written by loading that word again and finding its original contents. A second hard case is a request held high through ST_ACCESS, which must not be accepted twice. The bench keeps req_valid asserted across the edge that leaves ST_ACCESS and then confirms that the next cycle is idle with no memory strobe.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;

    typedef enum logic [2:0] {
        K_LDW = 3'd0,
        K_STW = 3'd1,
        K_LDB = 3'd2,
        K_STB = 3'd3,
        K_LDP = 3'd4,
        K_STP = 3'd5
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_RETURN,
        ST_FAULT
    } agu_state_e;

    typedef enum logic [2:0] {
        MC_REG,
        MC_PUSH,
        MC_IDX,
        MC_ABS,
        MC_POST,
        MC_POP,
        MC_FRAME
    } mode_class_e;

    localparam logic [7:0] MD_PUSH   = 8'h0f;
    localparam logic [7:0] MD_ABS    = 8'h1f;
    localparam logic [7:0] MD_POP    = 8'h2f;
    localparam logic [7:0] MD_FRAME0 = 8'h30;
    localparam logic [3:0] SP_IDX    = 4'd14;

    function automatic mode_class_e classify(input logic [7:0] m);
        if (m < MD_PUSH)        return MC_REG;
        else if (m == MD_PUSH)  return MC_PUSH;
        else if (m < MD_ABS)    return MC_IDX;
        else if (m == MD_ABS)   return MC_ABS;
        else if (m < MD_POP)    return MC_POST;
        else if (m == MD_POP)   return MC_POP;
        else                    return MC_FRAME;
    endfunction

endpackage

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc
    import lsu_agu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [7:0]        mode,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] sp,
    input  logic [DATA_W-1:0] imm,
    input  logic              is_prog,
    output logic [DATA_W:0]   ea,
    output logic              wb_need,
    output logic [3:0]        wb_idx,
    output logic [DATA_W-1:0] wb_value
);
    localparam int LANES = DATA_W / 8;
    localparam logic [DATA_W-1:0] STEP = DATA_W'(LANES);

    logic [DATA_W-1:0] ea_data;
    logic [DATA_W-1:0] frame_off;
    logic              wb_raw;

    assign frame_off = DATA_W'(mode - MD_FRAME0);

    always_comb begin
        ea_data  = base;
        wb_raw   = 1'b0;
        wb_idx   = mode[3:0];
        wb_value = base;
        unique case (classify(mode))
            MC_REG: begin
                ea_data = base;
            end
            MC_PUSH: begin
                ea_data  = sp - STEP;
                wb_raw   = 1'b1;
                wb_idx   = SP_IDX;
                wb_value = sp - STEP;
            end
            MC_IDX: begin
                ea_data = base + imm;
            end
            MC_ABS: begin
                ea_data = imm;
            end
            MC_POST: begin
                ea_data  = base;
                wb_raw   = 1'b1;
                wb_value = base + imm;
            end
            MC_POP: begin
                ea_data  = sp;
                wb_raw   = 1'b1;
                wb_idx   = SP_IDX;
                wb_value = sp + STEP;
            end
            MC_FRAME: begin
                ea_data = sp + frame_off;
            end
            default: begin
                ea_data = base;
            end
        endcase
    end

    assign ea      = is_prog ? {base, 1'b0} : {1'b0, ea_data};
    assign wb_need = wb_raw && !is_prog;

endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer #(
    parameter int DATA_W = 16
) (
    input  logic                             is_byte,
    input  logic [((DATA_W/8)>1 ? $clog2(DATA_W/8) : 1)-1:0] sel,
    input  logic [DATA_W-1:0]                src,
    output logic [DATA_W/8-1:0]              be,
    output logic [DATA_W-1:0]                wdata
);
    localparam int LANES = DATA_W / 8;
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g]          = is_byte ? (sel == SEL_W'(g)) : 1'b1;
        assign wdata[g*8 +: 8] = is_byte ? src[7:0] : src[g*8 +: 8];
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
    parameter int DATA_W = 16
) (
    input  logic                             is_byte,
    input  logic [((DATA_W/8)>1 ? $clog2(DATA_W/8) : 1)-1:0] sel,
    input  logic [DATA_W-1:0]                rdata,
    output logic [DATA_W-1:0]                data
);
    localparam int LANES = DATA_W / 8;
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [7:0] picked;

    always_comb begin
        picked = rdata[7:0];
        for (int i = 0; i < LANES; i++) begin
            if (sel == SEL_W'(i)) picked = rdata[i*8 +: 8];
        end
    end

    assign data = is_byte ? {{(DATA_W-8){1'b0}}, picked} : rdata;

endmodule

// File: rtl/byte_lsu_agu.sv
module byte_lsu_agu
    import lsu_agu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [7:0]        req_mode,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] sp_val,
    input  logic [DATA_W-1:0] imm_val,
    input  logic [DATA_W-1:0] st_data,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DATA_W:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_en,
    output logic [3:0]        wb_reg,
    output logic [DATA_W-1:0] wb_val,
    output logic              fault,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);
    localparam int LANES = DATA_W / 8;
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

    agu_state_e state, nxt;
    acc_kind_e  kind;

    logic              is_prog, is_byte, is_store, is_word_data, misalign, take;
    logic [DATA_W:0]   ea;
    logic              wb_need;
    logic [3:0]        wb_idx;
    logic [DATA_W-1:0] wb_value;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] lane_wdata;

    logic              cap_store, cap_byte, cap_wb;
    logic [DATA_W:0]   cap_addr;
    logic [LANES-1:0]  cap_be;
    logic [DATA_W-1:0] cap_wdata;
    logic [3:0]        cap_wb_idx;
    logic [DATA_W-1:0] cap_wb_val;

    assign kind         = acc_kind_e'(req_kind);
    assign is_prog      = (kind == K_LDP) || (kind == K_STP);
    assign is_byte      = (kind == K_LDB) || (kind == K_STB);
    assign is_store     = (kind == K_STW) || (kind == K_STB) || (kind == K_STP);
    assign is_word_data = (kind == K_LDW) || (kind == K_STW);
    assign misalign     = is_word_data && (ea[SEL_W-1:0] != '0);
    assign take         = (state == ST_IDLE) && req_valid;

    lsu_ea_calc #(.DATA_W(DATA_W)) i_ea (
        .mode     (req_mode),
        .base     (base_val),
        .sp       (sp_val),
        .imm      (imm_val),
        .is_prog  (is_prog),
        .ea       (ea),
        .wb_need  (wb_need),
        .wb_idx   (wb_idx),
        .wb_value (wb_value)
    );

    lsu_lane_steer #(.DATA_W(DATA_W)) i_steer (
        .is_byte (is_byte),
        .sel     (ea[SEL_W-1:0]),
        .src     (st_data),
        .be      (lane_be),
        .wdata   (lane_wdata)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) i_extract (
        .is_byte (cap_byte),
        .sel     (cap_addr[SEL_W-1:0]),
        .rdata   (mem_rdata),
        .data    (ld_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = misalign ? ST_FAULT : ST_ACCESS;
            ST_ACCESS: nxt = cap_store ? ST_IDLE : ST_RETURN;
            ST_RETURN: nxt = ST_IDLE;
            ST_FAULT:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Request capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_store  <= 1'b0;
            cap_byte   <= 1'b0;
            cap_wb     <= 1'b0;
            cap_addr   <= '0;
            cap_be     <= '0;
            cap_wdata  <= '0;
            cap_wb_idx <= '0;
            cap_wb_val <= '0;
        end else if (take) begin
            cap_store  <= is_store;
            cap_byte   <= is_byte;
            cap_wb     <= wb_need;
            cap_addr   <= ea;
            cap_be     <= lane_be;
            cap_wdata  <= lane_wdata;
            cap_wb_idx <= wb_idx;
            cap_wb_val <= wb_value;
        end
    end

    // State-decoded outputs
    always_comb begin
        busy     = 1'b1;
        mem_en   = 1'b0;
        mem_we   = 1'b0;
        wb_en    = 1'b0;
        fault    = 1'b0;
        ld_valid = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_ACCESS: begin
                mem_en = 1'b1;
                mem_we = cap_store;
                wb_en  = cap_wb;
            end
            ST_RETURN: ld_valid = 1'b1;
            ST_FAULT:  fault = 1'b1;
            default:   busy = 1'b1;
        endcase
    end

    assign mem_addr  = cap_addr;
    assign mem_be    = cap_be;
    assign mem_wdata = cap_wdata;
    assign wb_reg    = cap_wb_idx;
    assign wb_val    = cap_wb_val;

endmodule

// File: rtl/byte_lsu_agu_checker.sv
module byte_lsu_agu_checker #(
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                c_busy,
    input logic                c_mem_en,
    input logic                c_mem_we,
    input logic [DATA_W:0]     c_mem_addr,
    input logic [DATA_W/8-1:0] c_mem_be,
    input logic                c_wb_en,
    input logic                c_fault,
    input logic                c_ld_valid,
    input logic [DATA_W-1:0]   c_ld_data
);
    localparam int LANES = DATA_W / 8;

    a_r10_fault_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
        c_fault |-> (!c_mem_en && !c_wb_en && !c_ld_valid));

    a_r10_fault_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        c_fault |=> !c_fault);

    a_r11_access_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        c_mem_en |=> !c_mem_en);

    a_r11_busy_when_active: assert property (@(posedge clk) disable iff (!rst_n)
        (c_mem_en || c_fault || c_ld_valid) |-> c_busy);

    a_r8_result_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        c_ld_valid |-> $past(c_mem_en && !c_mem_we));

    a_r8_byte_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ld_valid && ($past(c_mem_be) != {LANES{1'b1}})) |-> (c_ld_data[DATA_W-1:8] == '0));

    a_r7_word_even_address: assert property (@(posedge clk) disable iff (!rst_n)
        (c_mem_en && (c_mem_be == {LANES{1'b1}})) |-> !c_mem_addr[0]);

    a_r7_byte_lane_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (c_mem_en && ($countones(c_mem_be) == 1)) |-> c_mem_be[c_mem_addr[0]]);

endmodule

bind byte_lsu_agu byte_lsu_agu_checker #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .c_busy     (busy),
    .c_mem_en   (mem_en),
    .c_mem_we   (mem_we),
    .c_mem_addr (mem_addr),
    .c_mem_be   (mem_be),
    .c_wb_en    (wb_en),
    .c_fault    (fault),
    .c_ld_valid (ld_valid),
    .c_ld_data  (ld_data)
);

// File: tb/test_byte_lsu_agu.sv
`timescale 1ns/1ps
module test_byte_lsu_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [7:0]  req_mode = '0;
    logic [15:0] base_val = '0, sp_val = '0, imm_val = '0, st_data = '0;
    logic        busy, mem_en, mem_we, wb_en, fault, ld_valid;
    logic [16:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata, wb_val, ld_data;
    logic [15:0] mem_rdata = '0;
    logic [3:0]  wb_reg;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    byte_lsu_agu i_byte_lsu_agu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_mode(req_mode), .base_val(base_val), .sp_val(sp_val), .imm_val(imm_val),
        .st_data(st_data), .busy(busy), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_reg(wb_reg), .wb_val(wb_val),
        .fault(fault), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // Behavioural memory: sparse contents over a computed background pattern
    logic [15:0] mem [int];

    function automatic int rd_word(input int idx);
        if (mem.exists(idx)) return int'(mem[idx]);
        return (idx * 16'h1357 + 16'h2468) & 16'hFFFF;
    endfunction

    always @(posedge clk) begin
        if (mem_en) begin
            int idx;
            int cur;
            idx = int'(mem_addr >> 1);
            if (mem_we) begin
                cur = rd_word(idx);
                if (mem_be[0]) cur = (cur & 16'hFF00) | int'(mem_wdata[7:0]);
                if (mem_be[1]) cur = (cur & 16'h00FF) | (int'(mem_wdata[15:8]) << 8);
                mem[idx] = 16'(cur);
            end else begin
                mem_rdata <= 16'(rd_word(idx));
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference address model
    function automatic void ref_ea(input int k, input int md, input int b, input int s,
                                   input int im, output int a, output bit w,
                                   output int wr, output int wv);
        w = 0; wr = md & 15; wv = 0;
        if (k >= 4) begin a = b * 2; return; end
        if (md <= 14) a = b;
        else if (md == 15) begin a = (s - 2) & 65535; w = 1; wr = 14; wv = a; end
        else if (md <= 30) a = (b + im) & 65535;
        else if (md == 31) a = im;
        else if (md <= 46) begin a = b; w = 1; wv = (b + im) & 65535; end
        else if (md == 47) begin a = s; w = 1; wr = 14; wv = (s + 2) & 65535; end
        else a = (s + md - 48) & 65535;
    endfunction

    task automatic idle_chk(input string tag);
        chk(tag, "busy", int'(busy), 0);
        chk(tag, "mem_en", int'(mem_en), 0);
        chk(tag, "fault", int'(fault), 0);
        chk(tag, "ld_valid", int'(ld_valid), 0);
        chk(tag, "wb_en", int'(wb_en), 0);
    endtask

    task automatic run(input int k, input int md, input int b, input int s, input int im,
                       input int sd, input bit hold, input string tag);
        int a, wr, wv, be, wd, ld;
        bit w, flt, st;
        ref_ea(k, md, b, s, im, a, w, wr, wv);
        st  = (k % 2) == 1;
        flt = (k < 2) && ((a & 1) == 1);
        be  = (k == 2 || k == 3) ? (((a & 1) == 1) ? 2 : 1) : 3;
        wd  = (k == 3) ? ((sd & 255) * 257) : (sd & 65535);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(k); req_mode = 8'(md);
        base_val = 16'(b); sp_val = 16'(s); imm_val = 16'(im); st_data = 16'(sd);
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        chk(tag, "busy", int'(busy), 1);
        chk(tag, "fault", int'(fault), int'(flt));
        chk(tag, "mem_en", int'(mem_en), int'(!flt));
        chk(tag, "wb_en", int'(wb_en), int'(w && !flt));
        if (!flt) begin
            chk(tag, "mem_we", int'(mem_we), int'(st));
            chk(tag, "mem_addr", int'(mem_addr), a);
            chk(tag, "mem_be", int'(mem_be), be);
            if (st) chk(tag, "mem_wdata", int'(mem_wdata), wd);
            if (w) begin
                chk(tag, "wb_reg", int'(wb_reg), wr);
                chk(tag, "wb_val", int'(wb_val), wv);
            end
        end else begin
            chk(tag, "mem_we", int'(mem_we), 0);
        end
        if (!flt && !st) begin
            ld = rd_word(a >> 1);
            if (k == 2) ld = ((a & 1) == 1) ? ((ld >> 8) & 255) : (ld & 255);
            @(negedge clk);
            chk(tag, "ld_valid", int'(ld_valid), 1);
            chk(tag, "ld_data", int'(ld_data), ld);
            chk(tag, "mem_en", int'(mem_en), 0);
        end
        if (hold) begin
            @(posedge clk);
            #1;
        end
        req_valid = 1'b0;
        @(negedge clk);
        idle_chk({tag, " R11 idle"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_chk("R12 reset");
        chk("R12", "mem_we", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R12 after release");

        // R1 register indirect, word and byte loads (R8)
        run(0, 8'h03, 16'h1000, 16'h8000, 0, 0, 0, "R1 ldw r3");
        run(2, 8'h05, 16'h1001, 16'h8000, 0, 0, 0, "R8 ldb odd");
        run(2, 8'h0e, 16'h1002, 16'h8000, 0, 0, 0, "R8 ldb even");
        // R2 push then R5 pop of the same word
        run(1, 8'h0f, 16'h0000, 16'h8000, 0, 16'hBEEF, 0, "R2 push");
        run(0, 8'h2f, 16'h0000, 16'h7FFE, 0, 0, 0, "R5 pop");
        chk("R5 pop data", "mem", rd_word(16'h7FFE >> 1), 16'hBEEF);
        // R3 indexed, wraparound, absolute
        run(0, 8'h1a, 16'h0100, 16'h8000, 16'h0F00, 0, 0, "R3 indexed");
        run(0, 8'h10, 16'hFFF0, 16'h8000, 16'h0020, 0, 0, "R3 wrap");
        run(1, 8'h1f, 16'h5555, 16'h8000, 16'h2222, 16'h1234, 0, "R3 absolute");
        run(0, 8'h10, 16'h2220, 16'h8000, 16'h0002, 0, 0, "R3 readback");
        // R4 post-update
        run(0, 8'h27, 16'h3000, 16'h8000, 16'h0006, 0, 0, "R4 post-update");
        run(3, 8'h2d, 16'h3001, 16'h8000, 16'hFFFF, 16'h0077, 0, "R4 post-update byte");
        // R6 frame-relative extremes
        run(0, 8'h30, 16'h0000, 16'h4000, 0, 0, 0, "R6 frame 0");
        run(2, 8'hff, 16'h0000, 16'h4000, 0, 0, 0, "R6 frame cf");
        run(2, 8'h31, 16'h0000, 16'hFFFE, 0, 0, 0, "R6 frame wrap");
        // R7 lanes: byte stores to each lane, word store
        run(3, 8'h01, 16'h5001, 16'h8000, 0, 16'h12AB, 0, "R7 stb odd");
        run(3, 8'h01, 16'h5000, 16'h8000, 0, 16'h34CD, 0, "R7 stb even");
        run(0, 8'h01, 16'h5000, 16'h8000, 0, 0, 0, "R7 merged");
        chk("R7 merged word", "mem", rd_word(16'h2800), 16'hABCD);
        run(1, 8'h02, 16'h6000, 16'h8000, 0, 16'hA5C3, 0, "R7 stw");
        // R9 program word: mode ignored, full 17-bit reach
        run(4, 8'h0f, 16'hC000, 16'h8000, 16'h1111, 0, 0, "R9 ldp");
        run(5, 8'h2f, 16'h8001, 16'h8000, 0, 16'h0F0F, 0, "R9 stp");
        chk("R9 stp high region", "mem", rd_word(32'h8001), 16'h0F0F);
        run(4, 8'h00, 16'h8001, 16'h8000, 0, 0, 0, "R9 ldp readback");
        // R10 faults: odd word address, including push with odd stack pointer
        run(0, 8'hff, 16'h0000, 16'h4000, 0, 0, 0, "R10 frame odd word");
        run(1, 8'h0f, 16'h0000, 16'h7001, 0, 16'hDEAD, 0, "R10 push odd sp");
        run(0, 8'h10, 16'h6FFE, 16'h8000, 16'h0000, 0, 0, "R10 no write");
        chk("R10 memory untouched", "mem", rd_word(16'h37FF), (16'h37FF * 16'h1357 + 16'h2468) & 16'hFFFF);
        run(1, 8'h20, 16'h0101, 16'h8000, 16'h0004, 16'h1, 0, "R10 post odd");
        // R11 request held while busy is ignored
        run(1, 8'h03, 16'h7000, 16'h8000, 0, 16'h4242, 1, "R11 held request");

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog R11 actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule